// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag and valid state for a small set-associative cache. The number of ways is a parameter. A requester offers a 32-bit byte address through a ready/valid handshake. The block splits the address into tag, set index and block offset. It compares the tag against every way of the indexed set and reports hit or miss together with a way number. The data array, byte selection and write policy belong to the surrounding cache and are not part of this block.

On a miss the block raises a fill request that carries the tag and set. It then waits for the backing side to signal completion, and only then installs the tag. The way it installs into is chosen in this order: the lowest-numbered invalid way of the set, or the least-recently-used way if every way is valid. Each set keeps its own recency order, and a hit or a fill touches that order. Three running counters record hits, misses, and the misses that evicted a valid block.

The controller has three states:
- IDLE: ready for a request. It moves to LOOKUP when a request is accepted.
- LOOKUP: the response cycle. It returns to IDLE on a hit and moves to FILL on a miss.
- FILL: waits for fill completion. It returns to IDLE when `fill_done` is sampled high.

Top module: `cache_tag_dir`

## Requirements
- R1: With the default geometry (256 bytes, 32-byte lines, 2 ways, so 4 sets), the tag is address bits 31..7 and the set is bits 6..5. Bits 4..0 have no effect on hit, way or counters.
- R2: `req_ready` is high only in IDLE. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `resp_valid` is high for exactly the one cycle that follows acceptance.
- R3: `resp_hit` is 1 only when some way of the indexed set is valid and holds the address tag. On a hit, `resp_way` gives that way.
- R4: On a miss where the set has an invalid way, `resp_way` gives the lowest-numbered invalid way, that way is filled, and the replacement counter does not change.
- R5: On a miss where all ways are valid, `resp_way` gives the least-recently-used way. The replacement counter rises by one at the edge that ends the response cycle.
- R6: A hit, and a completed fill, make the accessed way the most recently used of its set.
- R7: After a miss, `fill_req` is high from the cycle after the response until the edge at which `fill_done` is sampled high. `fill_tag` and `fill_set` stay constant over that time. The tag becomes valid at that edge, and `req_ready` is high in the next cycle.
- R8: The hit counter (on a hit) or the miss counter (on a miss) rises by one at the edge that ends the response cycle. The counters do not change at any other time.
- R9: Synchronous reset `rst` (active high) clears every valid bit, the recency state and all counters, and returns the controller to IDLE.
- R10: A request presented while the block is busy (LOOKUP or FILL) is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the request |
| resp_valid | output | 1 | Lookup result valid this cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | WAY_W | Hit way, or the way chosen for the fill |
| fill_req | output | 1 | Line fetch outstanding |
| fill_tag | output | TAG_W | Tag of the line being fetched |
| fill_set | output | SET_W | Set of the line being fetched |
| fill_done | input | 1 | Line fetch complete |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| repl_count | output | CNT_W | Number of misses that evicted a valid line |

## Verification
The response is due in the cycle after the accepting edge. The counters move at the following edge, and `fill_req` also rises at that edge. The bench drives inputs on falling edges and samples the response at the first falling edge after acceptance. It samples the counters and the fill outputs one falling edge later. A behavioural model with per-way timestamps predicts hit, way and counts for every access. During fill waits of several lengths the bench holds a competing request and checks that `fill_req` holds, `req_ready` stays low, and no response appears afterwards.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL
    } dir_state_t;
endpackage

// File: rtl/cdir_way_store.sv
module cdir_way_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 25,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  valid_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld;
        logic             wr_here;

        assign wr_here = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
            end else if (wr_here) begin
                vld[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        assign valid_vec[w] = vld[lk_set];
        assign hit_vec[w]   = vld[lk_set] && (tag_mem[lk_set] == lk_tag);
    end

    // A tag is only installed after a miss, so two ways never hold it at once.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

// File: rtl/cdir_lru.sv
module cdir_lru #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] lk_set,
    output logic [WAY_W-1:0] victim_way
);
    // rank 0 = most recently used, WAYS-1 = least recently used
    logic [WAY_W-1:0] rank [SETS][WAYS];
    logic [WAY_W-1:0] touched_rank;
    logic [WAYS-1:0]  oldest_vec;

    assign touched_rank = rank[touch_set][touch_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    rank[touch_set][w] <= '0;
                end else if (rank[touch_set][w] < touched_rank) begin
                    rank[touch_set][w] <= rank[touch_set][w] + WAY_W'(1);
                end
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            oldest_vec[w] = (rank[lk_set][w] == WAY_W'(WAYS - 1));
            if (oldest_vec[w]) begin
                victim_way = WAY_W'(w);
            end
        end
    end

    // Ranks stay a permutation: exactly one way is the eviction candidate.
    assert_one_victim_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/cdir_stats.sv
module cdir_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_hit,
    input  logic             inc_miss,
    input  logic             inc_repl,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] repl_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count  <= '0;
            miss_count <= '0;
            repl_count <= '0;
        end else begin
            if (inc_hit)  hit_count  <= hit_count  + CNT_W'(1);
            if (inc_miss) miss_count <= miss_count + CNT_W'(1);
            if (inc_repl) repl_count <= repl_count + CNT_W'(1);
        end
    end

    assert_repl_is_miss_R5: assert property (@(posedge clk) disable iff (rst)
        inc_repl |-> inc_miss && !inc_hit);
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cdir_pkg::*;
#(
    parameter int CACHE_BYTES = 256,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 2,
    parameter int CNT_W       = 16,
    localparam int NUM_SETS   = CACHE_BYTES / (LINE_BYTES * WAYS),
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SET_W      = $clog2(NUM_SETS),
    localparam int TAG_W      = 32 - OFF_W - SET_W,
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [WAY_W-1:0] resp_way,
    output logic             fill_req,
    output logic [TAG_W-1:0] fill_tag,
    output logic [SET_W-1:0] fill_set,
    input  logic             fill_done,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] repl_count
);
    dir_state_t       state_q, state_d;
    logic [TAG_W-1:0] tag_q;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] fill_way_q;
    logic [WAYS-1:0]  hit_vec, valid_vec;
    logic [WAY_W-1:0] hit_way, free_way, victim_way, pick_way;
    logic             any_hit, all_valid, accept;
    logic             in_lookup, in_fill, fill_commit;
    logic             offset_unused;

    assign offset_unused = ^req_addr[OFF_W-1:0];
    assign accept        = req_valid && req_ready;
    assign in_lookup     = (state_q == ST_LOOKUP);
    assign in_fill       = (state_q == ST_FILL);
    assign fill_commit   = in_fill && fill_done;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            tag_q <= req_addr[31 -: TAG_W];
            set_q <= req_addr[OFF_W +: SET_W];
        end
        if (in_lookup) begin
            fill_way_q <= pick_way;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = any_hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = in_lookup;
        resp_hit   = in_lookup && any_hit;
        resp_way   = pick_way;
        fill_req   = in_fill;
        fill_tag   = tag_q;
        fill_set   = set_q;
    end

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])    hit_way  = WAY_W'(w);
            if (!valid_vec[w]) free_way = WAY_W'(w);
        end
        any_hit   = |hit_vec;
        all_valid = &valid_vec;
        pick_way  = any_hit ? hit_way : (all_valid ? victim_way : free_way);
    end

    cdir_way_store #(
        .WAYS(WAYS), .SETS(NUM_SETS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .lk_set(set_q), .lk_tag(tag_q),
        .wr_en(fill_commit), .wr_way(fill_way_q), .wr_set(set_q), .wr_tag(tag_q),
        .hit_vec(hit_vec), .valid_vec(valid_vec)
    );

    cdir_lru #(
        .WAYS(WAYS), .SETS(NUM_SETS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk(clk), .rst(rst),
        .touch_en((in_lookup && any_hit) || fill_commit),
        .touch_set(set_q),
        .touch_way(in_fill ? fill_way_q : hit_way),
        .lk_set(set_q),
        .victim_way(victim_way)
    );

    cdir_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst),
        .inc_hit(in_lookup && any_hit),
        .inc_miss(in_lookup && !any_hit),
        .inc_repl(in_lookup && !any_hit && all_valid),
        .hit_count(hit_count), .miss_count(miss_count), .repl_count(repl_count)
    );

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> resp_valid);
    assert_resp_single_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);
    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_done) |=> fill_req && $stable(fill_tag) && $stable(fill_set));
    assert_miss_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |=> fill_req);
    assert_hit_count_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |=> hit_count == $past(hit_count) + CNT_W'(1));
    assert_repl_count_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit && all_valid) |=> repl_count == $past(repl_count) + CNT_W'(1));
endmodule

// File: tb/cache_tag_dir_bench.sv
`timescale 1ns/1ps
module cache_tag_dir_bench;
    localparam int SETS = 4;
    localparam int WAYS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        resp_valid, resp_hit;
    logic [0:0]  resp_way;
    logic        fill_req;
    logic [24:0] fill_tag;
    logic [1:0]  fill_set;
    logic        fill_done = 1'b0;
    logic [15:0] hit_count, miss_count, repl_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model
    bit  m_valid [SETS][WAYS];
    int  m_tag   [SETS][WAYS];
    int  m_used  [SETS][WAYS];
    int  m_now   = 0;
    int  e_hits = 0, e_miss = 0, e_repl = 0;

    always #2 clk = ~clk;

    cache_tag_dir u_cache_tag_dir (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .fill_req(fill_req), .fill_tag(fill_tag),
        .fill_set(fill_set), .fill_done(fill_done), .hit_count(hit_count),
        .miss_count(miss_count), .repl_count(repl_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_counts();
        chk("R8 hit_count", int'(hit_count), e_hits);
        chk("R8 miss_count", int'(miss_count), e_miss);
        chk("R5 repl_count", int'(repl_count), e_repl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0;
                m_used[s][w]  = 0;
            end
        e_hits = 0; e_miss = 0; e_repl = 0;
        chk("R9 req_ready after reset", int'(req_ready), 1);
        chk("R9 resp_valid after reset", int'(resp_valid), 0);
        chk("R9 fill_req after reset", int'(fill_req), 0);
        check_counts();
    endtask

    task automatic access(input logic [31:0] a, input int delay);
        int tag, set, way, exp_way;
        bit hit, full;
        tag = int'(a[31:7]);
        set = int'(a[6:5]);
        @(negedge clk);
        chk("R2 req_ready idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        hit = 0; exp_way = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[set][w] && m_tag[set][w] == tag) begin hit = 1; exp_way = w; end
        full = 1;
        if (!hit) begin
            for (int w = WAYS - 1; w >= 0; w--)
                if (!m_valid[set][w]) begin full = 0; exp_way = w; end
            if (full) begin
                exp_way = 0;
                for (int w = 1; w < WAYS; w++)
                    if (m_used[set][w] < m_used[set][exp_way]) exp_way = w;
            end
        end
        way = exp_way;
        chk("R2 resp_valid after accept", int'(resp_valid), 1);
        chk("R3 resp_hit", int'(resp_hit), int'(hit));
        chk(hit ? "R3 hit way" : (full ? "R5 lru victim way" : "R4 lowest free way"),
            int'(resp_way), way);
        if (hit) begin
            e_hits++;
            m_now++;
            m_used[set][way] = m_now;
        end else begin
            e_miss++;
            if (full) e_repl++;
        end
        @(negedge clk);
        chk("R2 resp_valid single cycle", int'(resp_valid), 0);
        check_counts();
        if (hit) begin
            chk("R2 ready after hit", int'(req_ready), 1);
            chk("R7 no fill on hit", int'(fill_req), 0);
        end else begin
            chk("R7 fill_req raised", int'(fill_req), 1);
            chk("R7 fill_tag", int'(fill_tag), tag);
            chk("R7 fill_set", int'(fill_set), set);
            for (int i = 0; i < delay; i++) begin
                req_valid = 1'b1;
                req_addr  = a ^ 32'h8000_0000;
                @(negedge clk);
                chk("R10 busy not ready", int'(req_ready), 0);
                chk("R7 fill_req held", int'(fill_req), 1);
                chk("R7 fill_tag held", int'(fill_tag), tag);
            end
            req_valid = 1'b0;
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            chk("R7 fill_req dropped", int'(fill_req), 0);
            chk("R7 ready after fill", int'(req_ready), 1);
            chk("R10 busy request ignored", int'(resp_valid), 0);
            check_counts();
            m_valid[set][way] = 1;
            m_tag[set][way]   = tag;
            m_now++;
            m_used[set][way]  = m_now;
        end
    endtask

    initial begin
        logic [31:0] lcg;
        do_reset();
        // R1: tag 31..7, set 6..5; the sequence exercises fill, hit and LRU eviction
        access(32'hFF0040E0, 0);
        access(32'hBEEF0040, 2);
        access(32'h00101060, 1);
        access(32'hFF0040E0, 0);
        access(32'h00101060, 0);
        access(32'h002183E0, 3);   // R5: set full, evicts LRU way
        access(32'h00101060, 0);
        access(32'hFF0040E0, 1);   // R6: evicted earlier, misses again
        // R1: offset bits ignored
        access(32'h0010107F, 0);
        access(32'h00101061, 0);
        access(32'h00000000, 0);
        access(32'h00000010, 0);
        lcg = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            access({22'd0, 3'(lcg[27:25] % 5), 2'b00, lcg[12:11], lcg[4:0]},
                   int'(lcg[20:19]) % 3);
        end
        // R9: reset clears the directory
        do_reset();
        access(32'hFF0040E0, 0);
        access(32'hFF0040E0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule